// File: doc/BRIEF.md
# Modem Status Change Detector

This block watches four asynchronous handshake lines of a serial port: clear-to-send, data-set-ready, ring indicator and carrier detect. Each line passes through a synchronizer. The block compares the synchronized level with the level it saw on the previous cycle, and on a qualifying edge it latches a sticky change flag for that line. Clear-to-send, data-set-ready and carrier detect qualify on a change in either direction. The ring indicator qualifies only on a low-to-high change.

The block presents an eight-bit status byte. The low nibble holds the four change flags and the high nibble holds the current synchronized levels, so one read tells software which line moved and where it now sits. A one-cycle read strobe marks a read of that byte and clears the flags, which in turn drops the interrupt request. The interrupt request is the OR of the flags, gated by an enable pin. In the wider serial port this request has the lowest priority of all the interrupt sources. All pins are plain level or strobe signals: the block has no data stream, so there is no valid/ready handshake and no back-pressure.

Top module: `mstat_watch`

## Requirements
- R1: Status bits 7:4 show the synchronized levels of carrier detect (bit 7), ring indicator (bit 6), data-set-ready (bit 5) and clear-to-send (bit 4). A level driven on a pin appears there after the second rising clock edge.
- R2: A change in either direction on clear-to-send, data-set-ready or carrier detect sets status bit 0, 1 or 3 respectively. The flag becomes visible after the third rising clock edge that follows the pin change.
- R3: A low-to-high change on the ring indicator sets status bit 2 with the same latency as R2. A high-to-low change on the ring indicator sets no flag.
- R4: A set flag stays set for as long as no read strobe is sampled.
- R5: A read strobe sampled high at a clock edge clears every flag whose line shows no qualifying edge at that edge. A flag whose line has a qualifying edge at that same edge stays set.
- R6: The interrupt output is high exactly when the enable pin is high and at least one flag is set. Driving enable low masks the output but does not stop flags from latching.
- R7: While reset is held, all flags clear and the edge history loads the current synchronized levels. Levels held steady through reset therefore raise no flag after reset is released.
- R8: Changes on several lines at the same time each set their own flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| hs_clear_i | input | 1 | Clear-to-send line, asynchronous |
| hs_ready_i | input | 1 | Data-set-ready line, asynchronous |
| ring_i | input | 1 | Ring indicator line, asynchronous |
| carrier_i | input | 1 | Carrier detect line, asynchronous |
| rd_stb_i | input | 1 | One-cycle strobe marking a read of the status byte |
| irq_en_i | input | 1 | Interrupt enable |
| status_o | output | 8 | {levels[3:0], flags[3:0]} |
| irq_o | output | 1 | Interrupt request |

## Verification
A pin change made just after a clock edge appears in the level nibble after the second following rising edge and in the flag nibble after the third. The bench drives every stimulus on a falling edge. It then counts exactly two or three falling edges before it samples, and it checks that the flags are still clear at the two-edge point. The interrupt follows the flags with no extra register, so it is checked at the same sample point as the flags. To exercise R5, the read strobe is placed so that it is sampled at the very edge where a new flag latches.

// File: rtl/mstat_pkg.sv
package mstat_pkg;
  localparam int unsigned LINES   = 4;
  localparam int unsigned IDX_CTS = 0;
  localparam int unsigned IDX_DSR = 1;
  localparam int unsigned IDX_RI  = 2;
  localparam int unsigned IDX_DCD = 3;
  typedef logic [LINES-1:0] line_vec_t;
  // lines that qualify only on a low-to-high change
  localparam line_vec_t RISE_ONLY = line_vec_t'(1) << IDX_RI;
endpackage

// File: rtl/mstat_sync.sv
module mstat_sync #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk) stg[0] <= async_i;

  for (genvar k = 1; k < STAGES; k++) begin : g_stage
    always_ff @(posedge clk) stg[k] <= stg[k-1];

    // R1
    stage_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stg[k] == $past(stg[k-1]));
  end

  assign sync_o = stg[STAGES-1];
endmodule

// File: rtl/mstat_edge.sv
module mstat_edge #(
  parameter int unsigned      WIDTH     = 4,
  parameter logic [WIDTH-1:0] RISE_MASK = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] lvl_i,
  input  logic             rd_clr_i,
  output logic [WIDTH-1:0] flags_o
);
  logic [WIDTH-1:0] prev_q;
  logic [WIDTH-1:0] hit;
  logic [WIDTH-1:0] flags_q;

  for (genvar i = 0; i < WIDTH; i++) begin : g_line
    if (RISE_MASK[i]) begin : g_rise
      assign hit[i] = lvl_i[i] & ~prev_q[i];

      // R3
      rise_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags_q[i]) |-> $past(lvl_i[i]));
    end else begin : g_any
      assign hit[i] = lvl_i[i] ^ prev_q[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q  <= lvl_i;
      flags_q <= '0;
    end else begin
      prev_q  <= lvl_i;
      flags_q <= (flags_q & ~{WIDTH{rd_clr_i}}) | hit;
    end
  end

  assign flags_o = flags_q;

  // R4
  sticky_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_clr_i |=> ((flags_q & $past(flags_q)) == $past(flags_q)));

  // R5
  read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr_i && hit == '0) |=> flags_q == '0);
endmodule

// File: rtl/mstat_watch.sv
module mstat_watch #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hs_clear_i,
  input  logic       hs_ready_i,
  input  logic       ring_i,
  input  logic       carrier_i,
  input  logic       rd_stb_i,
  input  logic       irq_en_i,
  output logic [7:0] status_o,
  output logic       irq_o
);
  import mstat_pkg::*;

  line_vec_t raw;
  line_vec_t lvl;
  line_vec_t flags;

  always_comb begin
    raw          = '0;
    raw[IDX_CTS] = hs_clear_i;
    raw[IDX_DSR] = hs_ready_i;
    raw[IDX_RI]  = ring_i;
    raw[IDX_DCD] = carrier_i;
  end

  mstat_sync #(.WIDTH(LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .async_i(raw),
    .sync_o (lvl)
  );

  mstat_edge #(.WIDTH(LINES), .RISE_MASK(RISE_ONLY)) u_edge (
    .clk     (clk),
    .rst_n   (rst_n),
    .lvl_i   (lvl),
    .rd_clr_i(rd_stb_i),
    .flags_o (flags)
  );

  assign status_o = {lvl, flags};
  assign irq_o    = irq_en_i & (|flags);

  // R6
  irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en_i |-> !irq_o);

  // R6
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> status_o[3:0] != 4'h0);
endmodule

// File: tb/test_mstat_watch.sv
module test_mstat_watch;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] drv;
  logic       rd, en;
  logic [7:0] status;
  logic       irq;
  int         vecs = 0;
  int         bad  = 0;

  always #2.5 clk = ~clk;

  mstat_watch i_mstat_watch (
    .clk       (clk),
    .rst_n     (rst_n),
    .hs_clear_i(drv[0]),
    .hs_ready_i(drv[1]),
    .ring_i    (drv[2]),
    .carrier_i (drv[3]),
    .rd_stb_i  (rd),
    .irq_en_i  (en),
    .status_o  (status),
    .irq_o     (irq)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    vecs++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_flags(input logic [3:0] a, input logic [3:0] b);
    return ((a ^ b) & 4'b1011) | (~a & b & 4'b0100);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; drv = 4'hF; rd = 1'b0; en = 1'b1;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R7: levels held through reset raise no flag
    chk("R7 status after reset", status, 8'hF0);
    chk("R7 irq after reset", {7'd0, irq}, 8'h00);

    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        logic [3:0] ef;
        en  = a[0] ^ b[1];
        drv = 4'(a);
        repeat (4) @(negedge clk);
        rd = 1'b1;
        @(negedge clk);
        rd = 1'b0;
        // R5 read clears flags
        chk("R5 cleared by read", status, {4'(a), 4'h0});
        drv = 4'(b);
        repeat (2) @(negedge clk);
        // R1 level visible after two edges, flags not yet
        chk("R1 level nibble", status, {4'(b), 4'h0});
        @(negedge clk);
        ef = exp_flags(4'(a), 4'(b));
        // R2 R3 R8 flags after third edge
        chk("R2 R3 R8 flags", status, {4'(b), ef});
        // R6 irq gated by enable
        chk("R6 irq", {7'd0, irq}, {7'd0, en & (|ef)});
        repeat (3) @(negedge clk);
        // R4 flags sticky without read
        chk("R4 sticky", status, {4'(b), ef});
      end
    end

    // R5: edge coincident with read keeps its flag
    en = 1'b1;
    drv = 4'h0;
    repeat (4) @(negedge clk);
    rd = 1'b1; @(negedge clk); rd = 1'b0;
    drv = 4'b0001;
    repeat (4) @(negedge clk);
    chk("R5 setup cts flag", status, 8'h11);
    drv = 4'b0011;
    repeat (2) @(negedge clk);
    rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
    chk("R5 collision keeps new flag", status, 8'h32);
    chk("R6 irq after collision", {7'd0, irq}, 8'h01);

    // R3: ring falling alone sets nothing
    drv = 4'b0111;
    repeat (4) @(negedge clk);
    rd = 1'b1; @(negedge clk); rd = 1'b0;
    drv = 4'b0011;
    repeat (4) @(negedge clk);
    chk("R3 ring fall ignored", status, 8'h30);
    chk("R6 no irq on ring fall", {7'd0, irq}, 8'h00);

    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end
endmodule